// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This unit turns a 32-bit integer operand into an IEEE-754 binary value. The opcode picks one of three conversions:

- signed integer to single precision;
- unsigned integer to single precision;
- signed integer to double precision.

A plain move and a no-op sit in the same opcode space. Every operation takes one cycle. The operand, opcode and valid strobe are sampled on one clock edge, and the registered result appears together with its own valid strobe on the next edge.

All three conversions share one path. That path forms the magnitude, counts its leading zeros, normalises it, and then packs it twice: once into the single-precision layout and once into the double-precision layout. The single-precision packer rounds any magnitude with more than 24 significant bits to nearest, ties to even. The double-precision packer never needs to round, because a 53-bit significand holds any 32-bit integer. Single-precision results sit in the low half of the 64-bit result bus, and the upper half is zero.

Top module: `itof_convert`

## Requirements
- R1: With opcode 5 the source is read as a two's-complement signed integer and the result is its single-precision value. Bit 31 is the sign, bits 30:23 are the exponent biased by 127, and bits 22:0 are the fraction.
- R2: With opcode 6 the source is read as an unsigned integer and the result is its single-precision value, which is never negative.
- R3: A single-precision result whose magnitude needs more than 24 significant bits is rounded to nearest, ties to even. A carry out of the fraction raises the exponent, so 0xFFFFFFFF unsigned gives 0x4F800000.
- R4: With opcode 4 the source is read as a signed integer and the result is the exact double-precision value over all 64 bits. Bit 63 is the sign, bits 62:52 are the exponent biased by 1023, and bits 51:0 are the fraction.
- R5: A zero source gives +0.0, which is an all-zero result, for every conversion opcode.
- R6: The source 0x80000000 under a signed conversion gives exactly -2^31: 0xCF000000 in single precision and 0xC1E0000000000000 in double precision.
- R7: With opcode 1 the 32-bit source is copied unchanged to result bits 31:0.
- R8: For opcodes 1, 5 and 6, result bits 63:32 are zero.
- R9: The output valid strobe is high exactly in the cycle after an accepted input. Back-to-back inputs give back-to-back results in order.
- R10: Opcode 0, any opcode other than 0, 1, 4, 5 and 6, and cycles with the input valid low all leave the output valid low and the result unchanged.
- R11: While reset is asserted, the output valid is low and the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand and opcode are present this cycle |
| in_op | input | 8 | Operation select (0 no-op, 1 move, 4 signed to double, 5 signed to single, 6 unsigned to single) |
| in_src | input | 32 | Integer source operand |
| out_valid | output | 1 | Result is valid this cycle |
| out_result | output | 64 | Converted value; single results in bits 31:0 |

## Verification
On every cycle the assertions check the following:

- the one-cycle valid latency;
- the silence and held result for no-ops, unsupported opcodes and idle cycles;
- the zeroed upper half of single and move results;
- the sign bit of each conversion;
- the move copy;
- the +0.0 result for a zero source;
- the reset state.

The rounded fraction and exponent values can only be shown by the bench's scenarios. These cover tie cases that round up and that round down, a rounding carry into the exponent, the most negative integer, and a long mixed stream. Each result is compared with a reference model that finds its rounding point by integer division and remainder rather than by a guard and sticky bit.

// File: rtl/itof_pkg.sv
package itof_pkg;

  // Operation class after opcode decode
  typedef enum logic [2:0] {
    KIND_NONE = 3'd0,
    KIND_MOV  = 3'd1,
    KIND_SGN1 = 3'd2,  // signed -> single
    KIND_UNS1 = 3'd3,  // unsigned -> single
    KIND_SGN2 = 3'd4   // signed -> double
  } conv_kind_e;

  // Magnitude of a source word; reading as signed only when asked
  function automatic logic [31:0] src_magnitude(input logic [31:0] src, input logic as_signed);
    logic neg;
    neg = as_signed & src[31];
    return neg ? (~src + 32'd1) : src;
  endfunction

  // Round-to-nearest-even increment decision
  function automatic logic rne_increment(input logic lsb, input logic guard, input logic sticky);
    return guard & (sticky | lsb);
  endfunction

endpackage

// File: rtl/itof_lzc.sv
module itof_lzc #(
  parameter int W    = 32,
  parameter int LZ_W = $clog2(W)
) (
  input  logic [W-1:0]    vec,
  output logic [LZ_W-1:0] lz,
  output logic            all_zero
);
  // Scan upward; the highest set bit wins
  always_comb begin
    lz = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) lz = LZ_W'(W - 1 - i);
    end
    all_zero = ~|vec;
  end
endmodule

// File: rtl/itof_norm.sv
module itof_norm #(
  parameter int W    = 32,
  parameter int LZ_W = $clog2(W)
) (
  input  logic [W-1:0]    mag,
  output logic [W-1:0]    norm,
  output logic [LZ_W-1:0] lead_pos,
  output logic            is_zero
);
  logic [LZ_W-1:0] lz;

  itof_lzc #(.W(W), .LZ_W(LZ_W)) u_lzc (
    .vec      (mag),
    .lz       (lz),
    .all_zero (is_zero)
  );

  // Leading one moved to bit W-1; its position gives the unbiased exponent
  always_comb begin
    norm     = mag << lz;
    lead_pos = LZ_W'(W - 1) - lz;
  end
endmodule

// File: rtl/itof_pack.sv
module itof_pack import itof_pkg::*; #(
  parameter int W     = 32,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int LZ_W  = $clog2(W)
) (
  input  logic                   sign,
  input  logic [W-1:0]           norm,
  input  logic [LZ_W-1:0]        lead_pos,
  input  logic                   is_zero,
  output logic [EXP_W+MAN_W:0]   word,
  output logic                   round_up
);
  localparam int BODY_W = EXP_W + MAN_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int DROP   = W - 1 - MAN_W;  // bits below the kept fraction

  logic [MAN_W-1:0]  frac;
  logic [EXP_W-1:0]  exp_field;
  logic [BODY_W-1:0] body;

  generate
    if (DROP >= 2) begin : g_round
      logic guard_b, sticky_b;
      always_comb begin
        frac     = norm[W-2 -: MAN_W];
        guard_b  = norm[DROP-1];
        sticky_b = |norm[DROP-2:0];
        round_up = rne_increment(frac[0], guard_b, sticky_b);
      end
    end else begin : g_exact
      always_comb begin
        frac     = {norm[W-2:0], {(MAN_W - W + 1){1'b0}}};
        round_up = 1'b0;
      end
    end
  endgenerate

  // The increment on the joined exponent+fraction carries into the exponent
  always_comb begin
    exp_field = EXP_W'(BIAS) + EXP_W'(lead_pos);
    body      = {exp_field, frac} + BODY_W'(round_up);
    word      = is_zero ? '0 : {sign, body};
  end
endmodule

// File: rtl/itof_convert.sv
module itof_convert import itof_pkg::*; #(
  parameter int SRC_W   = 32,
  parameter int S_EXP_W = 8,
  parameter int S_MAN_W = 23,
  parameter int D_EXP_W = 11,
  parameter int D_MAN_W = 52,
  parameter int OP_W    = 8,
  parameter logic [OP_W-1:0] OP_NOP = 8'd0,
  parameter logic [OP_W-1:0] OP_MOV = 8'd1,
  parameter logic [OP_W-1:0] OP_I2D = 8'd4,
  parameter logic [OP_W-1:0] OP_I2S = 8'd5,
  parameter logic [OP_W-1:0] OP_U2S = 8'd6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OP_W-1:0] in_op,
  input  logic [31:0]     in_src,
  output logic            out_valid,
  output logic [63:0]     out_result
);
  localparam int S_W   = 1 + S_EXP_W + S_MAN_W;
  localparam int RES_W = 1 + D_EXP_W + D_MAN_W;
  localparam int LZ_W  = $clog2(SRC_W);

  conv_kind_e       kind;
  logic             as_signed;
  logic             conv_neg;
  logic [31:0]      conv_mag;
  logic [31:0]      norm;
  logic [LZ_W-1:0]  lead_pos;
  logic             conv_zero;
  logic [S_W-1:0]   s_word;
  logic [RES_W-1:0] d_word;
  logic             rnd_up32;
  logic             rnd_up64;
  logic             produce;
  logic [RES_W-1:0] next_result;

  // Opcode decode; OP_NOP and unknown codes both map to no result
  always_comb begin
    if      (in_op == OP_MOV) kind = KIND_MOV;
    else if (in_op == OP_I2S) kind = KIND_SGN1;
    else if (in_op == OP_U2S) kind = KIND_UNS1;
    else if (in_op == OP_I2D) kind = KIND_SGN2;
    else                      kind = KIND_NONE;
  end

  always_comb begin
    as_signed = (kind == KIND_SGN1) || (kind == KIND_SGN2);
    conv_neg  = as_signed & in_src[31];
    conv_mag  = src_magnitude(in_src, as_signed);
    produce   = in_valid && (kind != KIND_NONE);
  end

  itof_norm #(.W(SRC_W), .LZ_W(LZ_W)) u_norm (
    .mag      (conv_mag),
    .norm     (norm),
    .lead_pos (lead_pos),
    .is_zero  (conv_zero)
  );

  itof_pack #(.W(SRC_W), .EXP_W(S_EXP_W), .MAN_W(S_MAN_W), .LZ_W(LZ_W)) u_pack_s (
    .sign     (conv_neg),
    .norm     (norm),
    .lead_pos (lead_pos),
    .is_zero  (conv_zero),
    .word     (s_word),
    .round_up (rnd_up32)
  );

  itof_pack #(.W(SRC_W), .EXP_W(D_EXP_W), .MAN_W(D_MAN_W), .LZ_W(LZ_W)) u_pack_d (
    .sign     (conv_neg),
    .norm     (norm),
    .lead_pos (lead_pos),
    .is_zero  (conv_zero),
    .word     (d_word),
    .round_up (rnd_up64)
  );

  always_comb begin
    unique case (kind)
      KIND_MOV:             next_result = RES_W'(in_src);
      KIND_SGN1, KIND_UNS1: next_result = RES_W'(s_word);
      KIND_SGN2:            next_result = d_word;
      default:              next_result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= produce;
      if (produce) out_result <= next_result;
    end
  end
endmodule

// File: rtl/itof_convert_chk.sv
module itof_convert_chk #(
  parameter int OP_W = 8,
  parameter logic [OP_W-1:0] OP_NOP = 8'd0,
  parameter logic [OP_W-1:0] OP_MOV = 8'd1,
  parameter logic [OP_W-1:0] OP_I2D = 8'd4,
  parameter logic [OP_W-1:0] OP_I2S = 8'd5,
  parameter logic [OP_W-1:0] OP_U2S = 8'd6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [OP_W-1:0] in_op,
  input logic [31:0]     in_src,
  input logic            out_valid,
  input logic [63:0]     out_result,
  input logic            rnd_up32,
  input logic            conv_zero
);
  logic known_op, conv_op, single_op;
  always_comb begin
    known_op  = (in_op == OP_MOV) || (in_op == OP_I2D) || (in_op == OP_I2S) || (in_op == OP_U2S);
    conv_op   = (in_op == OP_I2D) || (in_op == OP_I2S) || (in_op == OP_U2S);
    single_op = (in_op == OP_MOV) || (in_op == OP_I2S) || (in_op == OP_U2S);
  end

  p_valid_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && known_op) |=> out_valid);
  p_unknown_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !known_op) |=> (!out_valid && $stable(out_result)));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_result)));
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && single_op) |=> (out_result[63:32] == 32'd0));
  p_move_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_MOV) |=> (out_result[31:0] == $past(in_src)));
  p_zero_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && conv_op && in_src == 32'd0) |=> (out_result == 64'd0));
  p_sign_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_I2S) |=> (out_result[31] == $past(in_src[31])));
  p_unsigned_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_U2S) |=> !out_result[31]);
  p_sign_double_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_I2D) |=> (out_result[63] == $past(in_src[31])));
  // R3: an increment only ever happens on a nonzero magnitude
  p_round_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_up32 |-> !conv_zero);
  p_reset_state_r11: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_result == 64'd0));
endmodule

bind itof_convert itof_convert_chk #(
  .OP_W(OP_W), .OP_NOP(OP_NOP), .OP_MOV(OP_MOV),
  .OP_I2D(OP_I2D), .OP_I2S(OP_I2S), .OP_U2S(OP_U2S)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .in_src     (in_src),
  .out_valid  (out_valid),
  .out_result (out_result),
  .rnd_up32   (rnd_up32),
  .conv_zero  (conv_zero)
);

// File: tb/itof_convert_bench.sv
module itof_convert_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] C_NOP = 8'd0, C_MOV = 8'd1, C_I2D = 8'd4, C_I2S = 8'd5, C_U2S = 8'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_op = '0;
  logic [31:0] in_src = '0;
  logic        out_valid;
  logic [63:0] out_result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [63:0] value;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  itof_convert u_itof_convert (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_src(in_src), .out_valid(out_valid), .out_result(out_result)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference single: rounding point found by quotient and remainder
  function automatic logic [31:0] ref_single(input logic [31:0] src, input bit signed_in);
    longint m, q, rem, half;
    int e, sh;
    bit neg;
    m = signed_in ? longint'($signed(src)) : longint'({32'd0, src});
    neg = (m < 0);
    if (neg) m = -m;
    if (m == 0) return 32'd0;
    e = 0;
    for (int i = 0; i < 40; i++) if ((m >> i) != 0) e = i;
    if (e <= 23) q = m << (23 - e);
    else begin
      sh = e - 23;
      q = m >> sh;
      rem = m - (q << sh);
      half = longint'(1) << (sh - 1);
      if (rem > half || (rem == half && q[0])) q = q + 1;
      if (q == (longint'(1) << 24)) begin q = q >> 1; e = e + 1; end
    end
    return {neg, 8'(e + 127), q[22:0]};
  endfunction

  function automatic logic [63:0] expect_of(input logic [7:0] op, input logic [31:0] src);
    case (op)
      C_MOV:   return {32'd0, src};
      C_I2S:   return {32'd0, ref_single(src, 1'b1)};
      C_U2S:   return {32'd0, ref_single(src, 1'b0)};
      C_I2D:   return $realtobits($itor($signed(src)));
      default: return 64'd0;
    endcase
  endfunction

  function automatic bit produces(input logic [7:0] op);
    return op == C_MOV || op == C_I2S || op == C_U2S || op == C_I2D;
  endfunction

  // Driver: one operation per cycle, expected value queued
  task automatic send(input logic [7:0] op, input logic [31:0] src, input string tag);
    exp_t it;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_src = src;
    if (produces(op)) begin
      it.value = expect_of(op, src);
      it.tag = tag;
      sb.push_back(it);
    end
  endtask

  task automatic send_fixed(input logic [7:0] op, input logic [31:0] src, input logic [63:0] val, input string tag);
    exp_t it;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_src = src;
    it.value = val; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // R10: no valid and unchanged result after the stimulus
  task automatic quiet(input bit vld, input logic [7:0] op, input logic [31:0] src, input string tag);
    logic [63:0] held;
    idle(2);
    @(negedge clk);
    held = out_result;
    in_valid = vld; in_op = op; in_src = src;
    @(negedge clk);
    check(!out_valid, tag, {63'd0, out_valid}, 64'd0);
    check(out_result == held, tag, out_result, held);
    in_valid = 1'b0;
  endtask

  // Monitor: pop and compare as results appear
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (sb.size() == 0) check(1'b0, "R9 unexpected valid", out_result, 64'd0);
        else begin
          exp_t it;
          it = sb.pop_front();
          check(out_result == it.value, it.tag, out_result, it.value);
        end
      end
    end
  end

  initial begin
    repeat (CLK_PERIOD * 5000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 64'd0, 64'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && out_result == 64'd0, "R11 reset state", out_result, 64'd0);
    rst_n = 1'b1;

    // R1 signed single
    send_fixed(C_I2S, 32'd1, 64'h3F800000, "R1 one");
    send_fixed(C_I2S, 32'hFFFFFFFF, 64'hBF800000, "R1 minus one");
    send_fixed(C_I2S, 32'hFFFFFF9C, 64'hC2C80000, "R1 minus 100");
    send_fixed(C_I2S, 32'h01000000, 64'h4B800000, "R1 2^24");
    // R2 unsigned single
    send_fixed(C_U2S, 32'h80000000, 64'h4F000000, "R2 2^31 unsigned");
    send(C_U2S, 32'd12345, "R2 small unsigned");
    // R3 rounding
    send_fixed(C_U2S, 32'hFFFFFFFF, 64'h4F800000, "R3 carry to exponent");
    send_fixed(C_I2S, 32'h01000001, 64'h4B800000, "R3 tie to even down");
    send_fixed(C_I2S, 32'h01000003, 64'h4B800002, "R3 tie to even up");
    send_fixed(C_I2S, 32'h7FFFFFFF, 64'h4F000000, "R3 max positive");
    send(C_I2S, 32'h01000005, "R3 tie down again");
    send(C_U2S, 32'h87654321, "R3 sticky");
    // R4 double
    send_fixed(C_I2D, 32'd1, 64'h3FF0000000000000, "R4 one");
    send_fixed(C_I2D, 32'h7FFFFFFF, 64'h41DFFFFFFFC00000, "R4 max");
    send(C_I2D, 32'hFFFFFF9C, "R4 negative");
    // R5 zero
    send_fixed(C_I2S, 32'd0, 64'd0, "R5 zero signed single");
    send_fixed(C_U2S, 32'd0, 64'd0, "R5 zero unsigned single");
    send_fixed(C_I2D, 32'd0, 64'd0, "R5 zero double");
    // R6 most negative
    send_fixed(C_I2S, 32'h80000000, 64'h00000000CF000000, "R6 single");
    send_fixed(C_I2D, 32'h80000000, 64'hC1E0000000000000, "R6 double");
    // R7 / R8 move
    send_fixed(C_MOV, 32'hDEADBEEF, 64'h00000000DEADBEEF, "R7 R8 move");
    idle(2);

    // R10 silent cases
    quiet(1'b1, C_NOP, 32'h12345678, "R10 nop");
    quiet(1'b1, 8'd3, 32'h00000007, "R10 opcode 3");
    quiet(1'b1, 8'd2, 32'hFFFFFFFF, "R10 opcode 2");
    quiet(1'b1, 8'hFF, 32'h00000001, "R10 opcode 255");
    quiet(1'b0, C_I2S, 32'h00000009, "R10 valid low");

    // R9 back-to-back mixed stream
    for (int i = 0; i < 400; i++) begin
      logic [7:0] op;
      logic [31:0] s;
      case ($urandom_range(0, 5))
        0: op = C_I2S; 1: op = C_U2S; 2: op = C_I2D;
        3: op = C_MOV; 4: op = C_NOP; default: op = 8'd7;
      endcase
      s = $urandom();
      if (i % 7 == 0) s = s >> $urandom_range(0, 31);
      send(op, s, "R9 stream");
    end
    idle(3);
    check(sb.size() == 0, "R9 all results delivered", 64'(sb.size()), 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule